// File: doc/BRIEF.md
# Interrupt Controller Command and Init Sequencer

This block is the byte-wide, two-address register front end of an eight-line programmable interrupt controller. A write to address 0 is decoded by its flag bits as one of three kinds: an initialization start, an operation-control command, or an end-of-interrupt / rotation command. Writes to address 1 feed a stepped initialization sequence. Once that sequence has finished, they load the interrupt mask instead. The block owns the mask, the in-service bits, the rotation base that sets which line has top priority, the vector base and the mode flags.

The request vector and the current winning line come from an external priority resolver. Reads return the request, in-service or mask byte one cycle after the read strobe. A read made while poll is armed returns the winner with bit 7 set and acknowledges that winner. A separate trigger-mode byte holds one bit per line. Only the bits allowed by a per-instance mask can be written. An initialization start that asks for level-sensitive operation raises an error flag.

Top module: `irqc_cmd_seq`

## Requirements
- R1: After synchronous reset, mask, in-service, rotation base, vector base, trigger mode, all mode flags, `init_busy`, `level_err`, `rdata` and `ack_pulse` are all zero.
- R2: An address-0 write with bit 4 set clears mask, in-service, rotation base, vector base, poll, read select, special mask, auto-EOI, rotate-on-auto-EOI and fully-nested mode. It latches bit 0 as need-word-4 and bit 1 as single mode, enters step 1 (`init_busy`=1) and copies bit 3 into `level_err`.
- R3: In step 1, an address-1 write sets `vec_base` to the data with bits [2:0] cleared. The sequence then goes to step 2 if single mode is clear, to step 3 if single mode and need-word-4 are both set, and otherwise ends.
- R4: In step 2, an address-1 write changes no register, and the sequence goes to step 3 if need-word-4 is set, otherwise it ends. In step 3, data bit 4 sets `sfnm`, bit 1 sets `auto_eoi`, and the sequence ends.
- R5: An address-1 write with no sequence in progress loads `imr`. During the sequence, `imr` is unchanged.
- R6: An address-0 write with bit 4 clear and bit 3 set arms poll when bit 2 is set. It sets read select to bit 0 only if bit 1 is set, and sets `spec_mask` to bit 5 only if bit 6 is set.
- R7: An address-0 write with bits 4 and 3 clear uses bits [7:5] as a code. Code 0 clears `rot_on_aeoi` and code 4 sets it.
- R8: Code 1 clears the in-service bit with highest priority. Priority starts at line `rot_base` and falls for each line above it, modulo 8. Code 5 does the same and also sets `rot_base` to that line + 1 mod 8. Neither code changes anything when no bit is in service.
- R9: Code 3 clears the in-service bit named by data[2:0]. Code 7 does the same and sets `rot_base` to that line + 1 mod 8. Code 6 sets `rot_base` to data[2:0] + 1 mod 8. Code 2 changes nothing.
- R10: A read with `wr_en` low and poll not armed places the following in `rdata` on the next cycle: `imr` for address 1, and for address 0 either `isr` (read select 1) or `req_vec` (read select 0).
- R11: A read with poll armed disarms poll. If `win_valid` is set, the next-cycle `rdata` is 0x80 OR `win_line`, `ack_pulse` is high for one cycle with `ack_line`=`win_line`, and the line is acknowledged. Acknowledging sets that `isr` bit when `auto_eoi` is 0. When `auto_eoi` is 1 it sets no `isr` bit, and if `rot_on_aeoi` is 1 it sets `rot_base` to line + 1 mod 8. If `win_valid` is clear, `rdata` is 0 and there is no acknowledge.
- R12: A `trig_we` write sets `trig_mode` to `trig_wdata` AND the `TRIG_WMASK` parameter (default 0xF8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (ignored while wr_en is high) |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| trig_we | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | 8 | Trigger-mode write data |
| req_vec | input | 8 | Request bits from the request logic |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | 3 | Winning line from the resolver |
| rdata | output | 8 | Registered read data |
| ack_pulse | output | 1 | One-cycle poll acknowledge |
| ack_line | output | 3 | Line acknowledged by poll |
| imr | output | 8 | Interrupt mask |
| isr | output | 8 | In-service bits |
| rot_base | output | 3 | Line that holds top priority |
| vec_base | output | 8 | Vector base |
| trig_mode | output | 8 | Per-line trigger mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| sfnm | output | 1 | Special fully nested mode |
| spec_mask | output | 1 | Special mask mode |
| init_busy | output | 1 | Initialization sequence in progress |
| level_err | output | 1 | Level-sensitive request seen at init start |

## Verification
Every state register this block owns is brought out as an output, so a wrong internal update shows on the ports one clock after the write that caused it. The main exception is a missed sequencer step, which shows up later: an address-1 write then either loads the mask when it should not, or leaves it alone when it should load it. A wrong read select or a poll flag that stays armed is only visible on the next read. For that reason the stimulus interleaves reads after every kind of control write. In-service and rotation errors are checked by comparing `isr` and `rot_base` after each write against a bench model of the rotating priority.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_step_t;

  localparam logic [2:0] CMD_AEOI_ROT_OFF = 3'd0;
  localparam logic [2:0] CMD_EOI_TOP      = 3'd1;
  localparam logic [2:0] CMD_NOP          = 3'd2;
  localparam logic [2:0] CMD_EOI_LINE     = 3'd3;
  localparam logic [2:0] CMD_AEOI_ROT_ON  = 3'd4;
  localparam logic [2:0] CMD_EOI_TOP_ROT  = 3'd5;
  localparam logic [2:0] CMD_SET_BASE     = 3'd6;
  localparam logic [2:0] CMD_EOI_LINE_ROT = 3'd7;
endpackage

// File: rtl/irqc_prio_find.sv
// Finds the set bit of highest rotating priority: line `base` first,
// then base+1, base+2 ... wrapping modulo N_LINES.
module irqc_prio_find #(
  parameter int N_LINES = 8,
  localparam int W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] vec,
  input  logic [W-1:0]       base,
  output logic               found,
  output logic [W-1:0]       line
);
  always_comb begin
    found = 1'b0;
    line  = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (vec[W'(int'(base) + i)]) begin
        found = 1'b1;
        line  = W'(int'(base) + i);
      end
    end
  end
endmodule

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       start_single,
  input  logic       start_need4,
  input  logic       step_wr,
  output init_step_t step
);
  logic single_q;
  logic need4_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= ST_IDLE;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
    end else if (start) begin
      step     <= ST_BASE;
      single_q <= start_single;
      need4_q  <= start_need4;
    end else if (step_wr) begin
      unique case (step)
        ST_BASE: begin
          if (!single_q)    step <= ST_CASC;
          else if (need4_q) step <= ST_MODE;
          else              step <= ST_IDLE;
        end
        ST_CASC: step <= need4_q ? ST_MODE : ST_IDLE;
        ST_MODE: step <= ST_IDLE;
        default: step <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irqc_cmd_seq.sv
module irqc_cmd_seq
  import irqc_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DW = 8,
  parameter logic [N_LINES-1:0] TRIG_WMASK = 8'hF8,
  localparam int W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [DW-1:0]      wdata,
  input  logic               trig_we,
  input  logic [N_LINES-1:0] trig_wdata,
  input  logic [N_LINES-1:0] req_vec,
  input  logic               win_valid,
  input  logic [W-1:0]       win_line,
  output logic [DW-1:0]      rdata,
  output logic               ack_pulse,
  output logic [W-1:0]       ack_line,
  output logic [N_LINES-1:0] imr,
  output logic [N_LINES-1:0] isr,
  output logic [W-1:0]       rot_base,
  output logic [DW-1:0]      vec_base,
  output logic [N_LINES-1:0] trig_mode,
  output logic               auto_eoi,
  output logic               rot_on_aeoi,
  output logic               sfnm,
  output logic               spec_mask,
  output logic               init_busy,
  output logic               level_err
);
  localparam logic [DW-1:0] VBASE_KEEP = ~DW'(N_LINES - 1);
  localparam logic [DW-1:0] POLL_FLAG  = DW'(1) << (DW - 1);

  logic       wr_cmd;
  logic       wr_data;
  logic       is_init;
  logic       is_opctl;
  logic       is_eoi;
  logic       rd_go;
  logic [2:0] code;
  logic [W-1:0] sel_line;
  logic       poll_armed;
  logic       rd_sel;
  logic       top_found;
  logic [W-1:0] top_line;
  init_step_t step;

  assign wr_cmd   = wr_en && !addr;
  assign wr_data  = wr_en && addr;
  assign is_init  = wr_cmd && wdata[4];
  assign is_opctl = wr_cmd && !wdata[4] && wdata[3];
  assign is_eoi   = wr_cmd && !wdata[4] && !wdata[3];
  assign code     = wdata[7:5];
  assign sel_line = wdata[W-1:0];
  assign rd_go    = rd_en && !wr_en;
  assign init_busy = (step != ST_IDLE);

  irqc_prio_find #(.N_LINES(N_LINES)) u_isr_find (
    .vec   (isr),
    .base  (rot_base),
    .found (top_found),
    .line  (top_line)
  );

  irqc_init_seq u_init_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (is_init),
    .start_single (wdata[1]),
    .start_need4  (wdata[0]),
    .step_wr      (wr_data && init_busy),
    .step         (step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_mode <= '0;
    end else if (trig_we) begin
      trig_mode <= trig_wdata & TRIG_WMASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imr         <= '0;
      isr         <= '0;
      rot_base    <= '0;
      vec_base    <= '0;
      auto_eoi    <= 1'b0;
      rot_on_aeoi <= 1'b0;
      sfnm        <= 1'b0;
      spec_mask   <= 1'b0;
      poll_armed  <= 1'b0;
      rd_sel      <= 1'b0;
      level_err   <= 1'b0;
      rdata       <= '0;
      ack_pulse   <= 1'b0;
      ack_line    <= '0;
    end else begin
      ack_pulse <= 1'b0;
      if (is_init) begin
        imr         <= '0;
        isr         <= '0;
        rot_base    <= '0;
        vec_base    <= '0;
        auto_eoi    <= 1'b0;
        rot_on_aeoi <= 1'b0;
        sfnm        <= 1'b0;
        spec_mask   <= 1'b0;
        poll_armed  <= 1'b0;
        rd_sel      <= 1'b0;
        level_err   <= wdata[3];
      end else if (is_opctl) begin
        if (wdata[2]) poll_armed <= 1'b1;
        if (wdata[1]) rd_sel <= wdata[0];
        if (wdata[6]) spec_mask <= wdata[5];
      end else if (is_eoi) begin
        unique case (code)
          CMD_AEOI_ROT_OFF, CMD_AEOI_ROT_ON: rot_on_aeoi <= code[2];
          CMD_EOI_TOP, CMD_EOI_TOP_ROT: begin
            if (top_found) begin
              isr[top_line] <= 1'b0;
              if (code == CMD_EOI_TOP_ROT) rot_base <= top_line + W'(1);
            end
          end
          CMD_EOI_LINE: isr[sel_line] <= 1'b0;
          CMD_EOI_LINE_ROT: begin
            isr[sel_line] <= 1'b0;
            rot_base      <= sel_line + W'(1);
          end
          CMD_SET_BASE: rot_base <= sel_line + W'(1);
          default: ;
        endcase
      end else if (wr_data) begin
        unique case (step)
          ST_IDLE: imr <= wdata[N_LINES-1:0];
          ST_BASE: vec_base <= wdata & VBASE_KEEP;
          ST_MODE: begin
            sfnm     <= wdata[4];
            auto_eoi <= wdata[1];
          end
          default: ;
        endcase
      end

      if (rd_go) begin
        poll_armed <= 1'b0;
        if (poll_armed) begin
          if (win_valid) begin
            rdata     <= POLL_FLAG | DW'(win_line);
            ack_pulse <= 1'b1;
            ack_line  <= win_line;
            if (auto_eoi) begin
              if (rot_on_aeoi) rot_base <= win_line + W'(1);
            end else begin
              isr[win_line] <= 1'b1;
            end
          end else begin
            rdata <= '0;
          end
        end else if (addr) begin
          rdata <= DW'(imr);
        end else begin
          rdata <= rd_sel ? DW'(isr) : DW'(req_vec);
        end
      end
    end
  end
endmodule

// File: rtl/irqc_cmd_seq_chk.sv
module irqc_cmd_seq_chk #(
  parameter int N_LINES = 8,
  parameter int DW = 8,
  parameter logic [N_LINES-1:0] TRIG_WMASK = 8'hF8,
  localparam int W = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               rd_en,
  input logic               addr,
  input logic [DW-1:0]      wdata,
  input logic               trig_we,
  input logic [N_LINES-1:0] trig_wdata,
  input logic [DW-1:0]      rdata,
  input logic               ack_pulse,
  input logic [W-1:0]       ack_line,
  input logic [N_LINES-1:0] imr,
  input logic [N_LINES-1:0] isr,
  input logic [N_LINES-1:0] trig_mode,
  input logic               init_busy,
  input logic               level_err,
  input logic               poll_armed
);
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4]) |=> (isr == '0 && imr == '0 && init_busy)); // R2
  AST_INIT_LEVEL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4]) |=> (level_err == $past(wdata[3]))); // R2
  AST_MASK_HELD_IN_INIT: assert property (@(posedge clk) disable iff (rst)
    (init_busy && !(wr_en && !addr && wdata[4])) |=> $stable(imr)); // R5
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |=> !ack_pulse); // R11
  AST_ACK_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |-> (rdata[DW-1] && rdata[W-1:0] == ack_line)); // R11
  AST_POLL_DISARM: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> !poll_armed); // R11
  AST_TRIG_MASKED: assert property (@(posedge clk) disable iff (rst)
    trig_we |=> (trig_mode == ($past(trig_wdata) & TRIG_WMASK))); // R12
endmodule

bind irqc_cmd_seq irqc_cmd_seq_chk #(
  .N_LINES(N_LINES), .DW(DW), .TRIG_WMASK(TRIG_WMASK)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .trig_we(trig_we), .trig_wdata(trig_wdata),
  .rdata(rdata), .ack_pulse(ack_pulse), .ack_line(ack_line),
  .imr(imr), .isr(isr), .trig_mode(trig_mode), .init_busy(init_busy),
  .level_err(level_err), .poll_armed(poll_armed)
);

// File: tb/irqc_cmd_seq_tb.sv
module irqc_cmd_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, trig_we = 1'b0;
  logic [7:0] wdata = '0, trig_wdata = '0, req_vec = '0;
  logic       win_valid = 1'b0;
  logic [2:0] win_line = '0;
  logic [7:0] rdata, imr, isr, vec_base, trig_mode;
  logic       ack_pulse, auto_eoi, rot_on_aeoi, sfnm, spec_mask, init_busy, level_err;
  logic [2:0] ack_line, rot_base;

  int n_chk = 0, n_fail = 0;

  // bench model of the requirements
  logic [7:0] m_imr, m_isr, m_vb, m_trig;
  logic [2:0] m_base;
  logic m_aeoi, m_raeoi, m_sfnm, m_smm, m_poll, m_rdsel, m_single, m_need4, m_lerr;
  int   m_step;

  always #4 clk = ~clk;

  irqc_cmd_seq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .trig_we(trig_we), .trig_wdata(trig_wdata),
    .req_vec(req_vec), .win_valid(win_valid), .win_line(win_line),
    .rdata(rdata), .ack_pulse(ack_pulse), .ack_line(ack_line),
    .imr(imr), .isr(isr), .rot_base(rot_base), .vec_base(vec_base),
    .trig_mode(trig_mode), .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi),
    .sfnm(sfnm), .spec_mask(spec_mask), .init_busy(init_busy),
    .level_err(level_err)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_state();
    chk("R5 imr", imr, m_imr);
    chk("R8 isr", isr, m_isr);
    chk("R9 rot_base", rot_base, m_base);
    chk("R3 vec_base", vec_base, m_vb);
    chk("R3 init_busy", init_busy, m_step != 0);
    chk("R4 modes", {auto_eoi, sfnm}, {m_aeoi, m_sfnm});
    chk("R6 spec_mask", spec_mask, m_smm);
    chk("R7 rot_on_aeoi", rot_on_aeoi, m_raeoi);
    chk("R2 level_err", level_err, m_lerr);
    chk("R12 trig_mode", trig_mode, m_trig);
  endtask

  function automatic int top_in_service(logic [7:0] v, logic [2:0] b);
    for (int i = 0; i < 8; i++)
      if (v[3'(b + 3'(i))]) return int'(3'(b + 3'(i)));
    return -1;
  endfunction

  task automatic model_clear();
    m_imr = 0; m_isr = 0; m_base = 0; m_vb = 0; m_aeoi = 0; m_raeoi = 0;
    m_sfnm = 0; m_smm = 0; m_poll = 0; m_rdsel = 0;
  endtask

  task automatic drive_resolver();
    req_vec   = 8'($urandom);
    win_valid = 1'($urandom);
    win_line  = 3'($urandom);
  endtask

  task automatic do_write(logic a, logic [7:0] d);
    int t;
    drive_resolver();
    wr_en = 1'b1; addr = a; wdata = d;
    if (!a && d[4]) begin
      model_clear(); m_lerr = d[3]; m_need4 = d[0]; m_single = d[1]; m_step = 1;
    end else if (!a && d[3]) begin
      if (d[2]) m_poll = 1;
      if (d[1]) m_rdsel = d[0];
      if (d[6]) m_smm = d[5];
    end else if (!a) begin
      case (d[7:5])
        3'd0, 3'd4: m_raeoi = d[7];
        3'd1, 3'd5: begin
          t = top_in_service(m_isr, m_base);
          if (t >= 0) begin
            m_isr[t] = 1'b0;
            if (d[7]) m_base = 3'(t + 1);
          end
        end
        3'd3: m_isr[d[2:0]] = 1'b0;
        3'd7: begin m_isr[d[2:0]] = 1'b0; m_base = d[2:0] + 3'd1; end
        3'd6: m_base = d[2:0] + 3'd1;
        default: ;
      endcase
    end else begin
      case (m_step)
        0: m_imr = d;
        1: begin m_vb = d & 8'hF8; m_step = !m_single ? 2 : (m_need4 ? 3 : 0); end
        2: m_step = m_need4 ? 3 : 0;
        default: begin m_sfnm = d[4]; m_aeoi = d[1]; m_step = 0; end
      endcase
    end
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk_state();
  endtask

  task automatic do_read(logic a);
    logic [7:0] exp_rd; logic exp_ack; logic [2:0] exp_line;
    drive_resolver();
    rd_en = 1'b1; addr = a;
    exp_ack = 0; exp_line = win_line;
    if (m_poll) begin
      if (win_valid) begin
        exp_rd = 8'h80 | {5'd0, win_line}; exp_ack = 1;
        if (m_aeoi) begin if (m_raeoi) m_base = win_line + 3'd1; end
        else m_isr[win_line] = 1'b1;
      end else exp_rd = 8'h00;
      m_poll = 0;
    end else exp_rd = a ? m_imr : (m_rdsel ? m_isr : req_vec);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk("R10 R11 rdata", rdata, exp_rd);
    chk("R11 ack_pulse", ack_pulse, exp_ack);
    if (exp_ack) chk("R11 ack_line", ack_line, exp_line);
    chk_state();
  endtask

  task automatic do_trig(logic [7:0] d);
    trig_we = 1'b1; trig_wdata = d; m_trig = d & 8'hF8;
    @(posedge clk); @(negedge clk);
    trig_we = 1'b0;
    chk_state();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [7:0] d;
    void'($urandom(32'd20240611));
    model_clear(); m_trig = 0; m_lerr = 0; m_step = 0; m_single = 0; m_need4 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 ack_pulse", ack_pulse, 0);
    chk_state();

    // directed: full sequence, cascade step data ignored (R3 R4)
    do_write(0, 8'h19);        // init, need4, level flag (R2)
    do_write(1, 8'hA7);        // base -> 0xA0 (R3)
    do_write(1, 8'hFF);        // step 2 ignored (R4)
    do_write(1, 8'h12);        // sfnm + auto_eoi (R4)
    do_write(1, 8'h5A);        // mask load (R5)
    // single mode without word 4 ends after base (R3)
    do_write(0, 8'h12);
    do_write(1, 8'h3F);
    do_write(1, 8'hC3);        // now a mask write (R5)
    // poll acknowledges into isr, then top-priority and rotating EOI (R8 R11)
    for (int k = 0; k < 3; k++) begin
      do_write(0, 8'h0C);
      win_valid = 1; do_read(0);
    end
    do_write(0, 8'hC4);        // base = 5 (R9)
    do_write(0, 8'hA0);        // rotating top EOI (R8)
    do_write(0, 8'h20);        // top EOI (R8)
    do_write(0, 8'h40);        // code 2 no-op (R9)
    do_write(0, 8'h0B); do_read(0); do_read(1);   // isr and mask read (R10)
    do_write(0, 8'h0A); do_read(0);                // request read (R10)
    do_trig(8'hFF);            // R12
    do_trig(8'h35);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int kind = int'($urandom % 16);
      d = 8'($urandom);
      if (kind == 0)       do_write(0, (d | 8'h10) & 8'h1F);
      else if (kind < 4)   do_write(0, {d[7:5], 2'b00, d[2:0]});
      else if (kind < 6)   do_write(0, {1'b0, d[6:5], 2'b01, d[2:0]});
      else if (kind < 9)   do_write(1, d);
      else if (kind < 11)  do_write(0, 8'h0C);
      else if (kind < 15)  do_read(d[0]);
      else                 do_trig(d);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule